// File: doc/BRIEF.md
# FIFO with Programmable Almost Flags

A 64-word synchronous first-in first-out buffer with four active-low status outputs: full, empty, almost-full and almost-empty. The almost threshold X is selected by a 2-bit flag-select input. The select is captured during reset and then held for the whole run. This version uses one clock for writing and reading. The write and read pointers are kept as separate registers, one bit wider than the address, so that the two sides can later be split into two clock domains.

Reset is active low and asynchronous. While it is held, the flags sit in a fixed state: full low, empty low, almost-empty low and almost-full high. After release, the buffer accepts no writes until the full flag rises. The full flag rises on the second rising clock edge after release. A write that arrives while the buffer is full is dropped. A read that arrives while it is empty is dropped. Read data comes out of a register that changes only when a read takes place.

Top module: `pfifo_top`

## Requirements
- R1: While rst_ni is low: full_no=0, empty_no=0, aempty_no=0, afull_no=1 and rd_data_o=0.
- R2: After rst_ni rises, full_no is still 0 after the first rising clock edge and is 1 after the second.
- R3: The threshold X is taken from fsel_i at the last rising clock edge while rst_ni is low, with the encoding 2'b00→4, 2'b01→8, 2'b10→12, 2'b11→16. Changes to fsel_i after release have no effect.
- R4: On a rising edge where wr_en_i=1 and full_no=1, wr_data_i is stored. Words leave in the order they were written.
- R5: On a rising edge where rd_en_i=1 and empty_no=1, the oldest word is loaded into rd_data_o. In every other case rd_data_o holds its value.
- R6: A write while full_no=0 is ignored. The stored words stay unchanged.
- R7: A read while empty_no=0 is ignored. rd_data_o and the stored contents do not change.
- R8: aempty_no is 0 exactly when the stored word count is less than or equal to X.
- R9: afull_no is 0 exactly when the number of free locations (64 minus the count) is less than or equal to X.
- R10: full_no is 0 when 64 words are stored. empty_no is 0 when no words are stored.
- R11: A write and a read accepted on the same edge leave the count unchanged.
- R12: Asserting reset while data is stored clears both pointers, so the buffer is empty afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fsel_i | input | 2 | Almost-flag threshold select, captured during reset |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | DATA_W | Write data |
| full_no | output | 1 | Low when full |
| afull_no | output | 1 | Low when almost full |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | DATA_W | Registered read data |
| empty_no | output | 1 | Low when empty |
| aempty_no | output | 1 | Low when almost empty |

## Verification
The bench builds the block with the default depth of 64 and the default 2-cycle startup, and narrows the data width to 16 bits. With a depth of 64, short runs of traffic reach both the full boundary and the empty boundary, so the bench can check writes dropped while full and reads dropped while empty. The bench repeats the same traffic table after a reset with each of the four select values. This places the almost-flag edges at counts 4, 8, 12 and 16 from the empty side and from the full side.

// File: rtl/pfifo_pkg.sv
package pfifo_pkg;
  typedef enum logic [1:0] {
    SEL_X1 = 2'b00,
    SEL_X2 = 2'b01,
    SEL_X3 = 2'b10,
    SEL_X4 = 2'b11
  } pfifo_sel_e;
endpackage

// File: rtl/pfifo_startup.sv
module pfifo_startup #(
  parameter int EDGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ready_o
);
  localparam int CW = $clog2(EDGES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (cnt_q != CW'(EDGES))     cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = (cnt_q == CW'(EDGES));

  // R2: once open, writes stay allowed until the next reset
  a_r2_ready_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
endmodule

// File: rtl/pfifo_offset.sv
module pfifo_offset
  import pfifo_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int STEP  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       sel_i,
  output logic [CNT_W-1:0] off_o
);
  logic [CNT_W-1:0] dec;
  logic [CNT_W-1:0] off_q;

  always_comb begin
    unique case (pfifo_sel_e'(sel_i))
      SEL_X1:  dec = CNT_W'(STEP * 1);
      SEL_X2:  dec = CNT_W'(STEP * 2);
      SEL_X3:  dec = CNT_W'(STEP * 3);
      default: dec = CNT_W'(STEP * 4);
    endcase
  end

  // loads every edge while reset is held; the last value before release is kept
  always_ff @(posedge clk_i) begin
    if (!rst_ni) off_q <= dec;
  end

  assign off_o = off_q;

  // R3: threshold frozen while out of reset
  a_r3_offset_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> $stable(off_q));
endmodule

// File: rtl/pfifo_mem.sv
module pfifo_mem #(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/pfifo_ctrl.sv
module pfifo_ctrl #(
  parameter int DEPTH = 64
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic                       rd_en_i,
  input  logic                       ready_i,
  input  logic [$clog2(DEPTH):0]     off_i,
  output logic                       wr_ok_o,
  output logic                       rd_ok_o,
  output logic [$clog2(DEPTH)-1:0]   waddr_o,
  output logic [$clog2(DEPTH)-1:0]   raddr_o,
  output logic                       full_no,
  output logic                       afull_no,
  output logic                       empty_no,
  output logic                       aempty_no
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int CNT_W  = ADDR_W + 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  // pointers carry a wrap bit so each side keeps its own register
  logic [CNT_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count;

  assign count     = wr_ptr_q - rd_ptr_q;
  assign full_no   = ready_i & (count != DEPTH_C);
  assign empty_no  = (count != '0);
  assign aempty_no = (count > off_i);
  assign afull_no  = ((DEPTH_C - count) > off_i);

  assign wr_ok_o = wr_en_i & full_no;
  assign rd_ok_o = rd_en_i & empty_no;
  assign waddr_o = wr_ptr_q[ADDR_W-1:0];
  assign raddr_o = rd_ptr_q[ADDR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (wr_ok_o) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (rd_ok_o) rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  a_r10_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= DEPTH_C);
  a_r6_full_blocks_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_no && wr_en_i) |=> wr_ptr_q == $past(wr_ptr_q));
  a_r7_empty_blocks_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_no && rd_en_i) |=> rd_ptr_q == $past(rd_ptr_q));
  a_r8_empty_implies_aempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty_no |-> !aempty_no);
  a_r9_full_implies_afull: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && !full_no) |-> !afull_no);
  a_r11_both_keep_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok_o && rd_ok_o) |=> count == $past(count));
endmodule

// File: rtl/pfifo_top.sv
module pfifo_top #(
  parameter int DATA_W        = 36,
  parameter int DEPTH         = 64,
  parameter int OFF_STEP      = 4,
  parameter int STARTUP_EDGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        fsel_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              full_no,
  output logic              afull_no,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              empty_no,
  output logic              aempty_no
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int CNT_W  = ADDR_W + 1;

  logic              ready;
  logic [CNT_W-1:0]  off;
  logic              wr_ok, rd_ok;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [DATA_W-1:0] mem_rdata;
  logic [DATA_W-1:0] rd_data_q;

  pfifo_startup #(.EDGES(STARTUP_EDGES)) u_startup (
    .clk_i(clk_i), .rst_ni(rst_ni), .ready_o(ready)
  );

  pfifo_offset #(.CNT_W(CNT_W), .STEP(OFF_STEP)) u_offset (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(fsel_i), .off_o(off)
  );

  pfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .ready_i(ready), .off_i(off), .wr_ok_o(wr_ok), .rd_ok_o(rd_ok),
    .waddr_o(waddr), .raddr_o(raddr), .full_no(full_no), .afull_no(afull_no),
    .empty_no(empty_no), .aempty_no(aempty_no)
  );

  pfifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk_i(clk_i), .we_i(wr_ok), .waddr_i(waddr), .wdata_i(wr_data_i),
    .raddr_i(raddr), .rdata_o(mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rd_data_q <= '0;
    else if (rd_ok) rd_data_q <= mem_rdata;
  end

  assign rd_data_o = rd_data_q;

  // R5: output register moves only on an accepted read
  a_r5_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && empty_no) |=> $stable(rd_data_o));
endmodule

// File: tb/pfifo_top_tb.sv
module pfifo_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int DEPTH = 64;
  localparam int NV = 7;
  // {wr, rd, repeat count}
  localparam logic [9:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'd20}, {1'b0, 1'b1, 8'd15}, {1'b1, 1'b1, 8'd10},
    {1'b1, 1'b0, 8'd70}, {1'b1, 1'b1, 8'd4},  {1'b0, 1'b1, 8'd70},
    {1'b1, 1'b1, 8'd5}
  };

  logic clk = 0;
  logic rst_ni = 0;
  logic [1:0] fsel = 0;
  logic wr_en = 0, rd_en = 0;
  logic [DW-1:0] wr_data = 0;
  logic full_no, afull_no, empty_no, aempty_no;
  logic [DW-1:0] rd_data;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [DW-1:0] mq [DEPTH];
  int mw, mr, mcnt, xoff;
  logic [DW-1:0] exp_rd;
  logic [DW-1:0] seq;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfifo_top #(.DATA_W(DW), .DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .fsel_i(fsel), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .full_no(full_no), .afull_no(afull_no),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .empty_no(empty_no),
    .aempty_no(aempty_no)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_flags();
    chk("R10 full_no", 64'(full_no), 64'(mcnt != DEPTH));
    chk("R10 empty_no", 64'(empty_no), 64'(mcnt != 0));
    chk("R8 aempty_no", 64'(aempty_no), 64'(mcnt > xoff));
    chk("R9 afull_no", 64'(afull_no), 64'((DEPTH - mcnt) > xoff));
  endtask

  // called at a falling edge
  task automatic do_reset(input logic [1:0] sel);
    rst_ni = 0;
    wr_en = 0;
    rd_en = 0;
    fsel = sel;
    #1;
    chk("R1 full_no", 64'(full_no), 64'd0);
    chk("R1 empty_no", 64'(empty_no), 64'd0);
    chk("R1 aempty_no", 64'(aempty_no), 64'd0);
    chk("R1 afull_no", 64'(afull_no), 64'd1);
    chk("R1 R12 rd_data_o", 64'(rd_data), 64'd0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_ni = 1;
    fsel = ~sel; // R3: must be ignored after release
    mw = 0; mr = 0; mcnt = 0; exp_rd = '0;
    xoff = 4 * (int'(sel) + 1);
    @(posedge clk); #1;
    chk("R2 full_no after first edge", 64'(full_no), 64'd0);
    @(posedge clk); #1;
    chk("R2 full_no after second edge", 64'(full_no), 64'd1);
    chk("R12 empty after reset", 64'(empty_no), 64'd0);
    @(negedge clk);
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input logic w, input logic r);
    bit wok, rok;
    wr_en = w;
    rd_en = r;
    wr_data = seq;
    wok = w && (mcnt != DEPTH);
    rok = r && (mcnt != 0);
    @(posedge clk); #1;
    if (rok) begin
      exp_rd = mq[mr];
      mr = (mr + 1) % DEPTH;
      mcnt--;
    end
    if (wok) begin
      mq[mw] = seq;
      mw = (mw + 1) % DEPTH;
      mcnt++;
    end
    seq++;
    if (rok) chk("R4 R5 R6 rd_data_o order", 64'(rd_data), 64'(exp_rd));
    else     chk("R7 rd_data_o hold", 64'(rd_data), 64'(exp_rd));
    chk_flags();
    @(negedge clk);
    wr_en = 0;
    rd_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    seq = 16'h1000;
    @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      do_reset(2'(s));
      chk_flags();
      for (int v = 0; v < NV; v++) begin
        for (int n = 0; n < int'(VEC[v][7:0]); n++) step(VEC[v][9], VEC[v][8]);
      end
    end
    // R12: reset with data stored, then refill to the threshold edge
    for (int n = 0; n < 30; n++) step(1'b1, 1'b0);
    do_reset(2'b11);
    for (int n = 0; n < 17; n++) step(1'b1, 1'b0);
    chk("R3 R8 aempty_no above 16", 64'(aempty_no), 64'd1);
    // R11: simultaneous access keeps every flag in place
    for (int n = 0; n < 3; n++) step(1'b1, 1'b1);
    chk("R11 count kept at 17", 64'(aempty_no), 64'd1);
    step(1'b0, 1'b1);
    chk("R8 aempty_no at 16", 64'(aempty_no), 64'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule